// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits on the host side of a 16-bit serial-input digital-to-analog converter. It takes one conversion code at a time over a valid/ready handshake. It then produces the chip-select, serial clock, serial data and update-strobe waveforms that the converter needs, and every interval in those waveforms is held for a whole number of system clock cycles. Each interval count is a parameter worked out from the system clock period. Every minimum is rounded up, so no setup, hold, phase-width or strobe limit can be violated at any clock rate.

After reset the sequencer waits out the converter's supply settling time before it accepts the first word. A frame starts by asserting chip-select and holding the clock low for a setup interval. Sixteen clock pulses follow, with the most significant bit first and the data changing on falling clock edges. A hold interval ends the frame before chip-select is released. The caller chooses the update method for each word. In direct mode the converter latches the word when chip-select rises, and the strobe line is held low. In strobe mode the strobe stays high through the frame and pulses low after a setup delay. A minimum chip-select-high gap always separates two frames.

Top module: `sdac_wr_seq`

## Requirements
- R1: After reset is released, `in_ready` stays low and no frame starts for exactly the power-up count of cycles (1000 at the default 20 ns clock period with a 20 µs wait). `in_ready` is high in the cycle after the 1000th rising edge, even if `in_valid` is held high the whole time.
- R2: While `rst` is high, `cs_n` is 1, `sclk` is 0, `latch_n` is 1 and `in_ready` is 0.
- R3: `in_ready` is high only while the sequencer is idle. A word is taken on the rising edge where `in_valid` and `in_ready` are both 1, and `cs_n` is 0 in the next cycle. Changes to `in_code`, `use_strobe` or `in_valid` while `in_ready` is low have no effect on the frame in progress.
- R4: After `cs_n` falls, `sclk` stays low for the chip-select setup count (3 cycles at defaults) before its first rise.
- R5: A frame has exactly 16 `sclk` high phases. Each high phase lasts the half-period count (3 cycles at defaults), and each pair of high phases is separated by a low phase of the same length. `sclk` is low whenever `cs_n` is high.
- R6: `sdo` shows code bit 15 from the cycle in which `cs_n` falls. After the i-th falling edge of `sclk` it shows bit 15-i. `sdo` never changes while `sclk` is high or at a rising edge of `sclk`.
- R7: `cs_n` stays low for the hold count (3 cycles at defaults) after the last `sclk` fall, so `cs_n` is low for 99 cycles per frame at defaults.
- R8: A word taken with `use_strobe` = 0 drives `latch_n` low from the cycle after acceptance. After `cs_n` rises, `cs_n` stays high for a gap of 5 cycles, and `in_ready` returns 104 cycles after the accepting edge.
- R9: A word taken with `use_strobe` = 1 keeps `latch_n` high while `cs_n` is low. `latch_n` goes low 3 cycles after `cs_n` rises and stays low for 3 cycles. The 5-cycle gap follows, and `in_ready` returns 110 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts the power-up wait |
| in_valid | input | 1 | A code is offered |
| in_ready | output | 1 | Sequencer is idle and takes the offered code |
| in_code | input | 16 | Code to send, bit 15 first |
| use_strobe | input | 1 | Update method for this code: 1 = strobe pulse, 0 = update on chip-select rise |
| cs_n | output | 1 | Active-low chip-select to the converter |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, changes on falling clock edges |
| latch_n | output | 1 | Active-low update strobe to the converter |

## Verification
The bench builds the block with its default parameters: a 20 ns system clock, 3-cycle clock phases, 3-cycle chip-select setup and hold, 3-cycle strobe setup and width, a 5-cycle gap and a 1000-cycle power-up wait. At these values a frame is only about a hundred cycles long. Every output can therefore be compared against an arithmetically computed waveform in every cycle of every frame, for both update methods, for walking-one, checkerboard, extreme and arithmetic code patterns, and for back-to-back words. The power-up window is short enough to check cycle by cycle with `in_valid` held high throughout.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_CSSU,
        ST_SHIFT,
        ST_CSHD,
        ST_STBSU,
        ST_STBLO,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic latch_n;
    } pin_bus_t;

    // Nanoseconds to whole clock cycles, rounded up, never below one cycle.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels that belong to a sequencer state.
    function automatic pin_bus_t pin_decode(input seq_state_e st, input logic hi,
                                            input logic strobe);
        pin_bus_t p;
        p.cs_n    = !((st == ST_CSSU) || (st == ST_SHIFT) || (st == ST_CSHD));
        p.sclk    = (st == ST_SHIFT) && hi;
        p.latch_n = strobe && (st != ST_STBLO);
        return p;
    endfunction

endpackage

// File: rtl/sdac_tmr.sv
module sdac_tmr #(
    parameter int                W       = 10,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sdac_shreg.sv
module sdac_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= din;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign msb = sh_q[W-1];
endmodule

// File: rtl/sdac_wr_seq.sv
module sdac_wr_seq
    import sdac_pkg::*;
#(
    parameter int CLK_NS             = 20,
    parameter int WORD_W             = 16,
    parameter int SCLK_MIN_PERIOD_NS = 100,
    parameter int SCLK_MIN_PHASE_NS  = 45,
    parameter int DATA_SETUP_NS      = 40,
    parameter int CS_SETUP_NS        = 45,
    parameter int CS_HOLD_NS         = 45,
    parameter int STB_SETUP_NS       = 50,
    parameter int STB_WIDTH_NS       = 50,
    parameter int CS_GAP_NS          = 100,
    parameter int PWRUP_NS           = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_code,
    input  logic              use_strobe,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdo,
    output logic              latch_n
);
    // Interval lengths in cycles, each rounded up from its minimum.
    localparam int HALF_CYC  = imax(imax(ns_to_cyc(SCLK_MIN_PHASE_NS, CLK_NS),
                                         ns_to_cyc(DATA_SETUP_NS, CLK_NS)),
                                    ns_to_cyc((SCLK_MIN_PERIOD_NS + 1) / 2, CLK_NS));
    localparam int CSSU_CYC  = imax(ns_to_cyc(CS_SETUP_NS, CLK_NS),
                                    ns_to_cyc(DATA_SETUP_NS, CLK_NS));
    localparam int CSHD_CYC  = ns_to_cyc(CS_HOLD_NS, CLK_NS);
    localparam int STBSU_CYC = ns_to_cyc(STB_SETUP_NS, CLK_NS);
    localparam int STBLO_CYC = ns_to_cyc(STB_WIDTH_NS, CLK_NS);
    localparam int GAP_CYC   = ns_to_cyc(CS_GAP_NS, CLK_NS);
    localparam int PWR_CYC   = ns_to_cyc(PWRUP_NS, CLK_NS);
    localparam int MAX_CYC   = imax(imax(imax(HALF_CYC, CSSU_CYC), imax(CSHD_CYC, STBSU_CYC)),
                                    imax(imax(STBLO_CYC, GAP_CYC), PWR_CYC));
    localparam int TMR_W     = $clog2(MAX_CYC + 1);
    localparam int BIT_W     = $clog2(WORD_W);

    localparam logic [TMR_W-1:0] HALF_LD  = TMR_W'(HALF_CYC - 1);
    localparam logic [TMR_W-1:0] CSSU_LD  = TMR_W'(CSSU_CYC - 1);
    localparam logic [TMR_W-1:0] CSHD_LD  = TMR_W'(CSHD_CYC - 1);
    localparam logic [TMR_W-1:0] STBSU_LD = TMR_W'(STBSU_CYC - 1);
    localparam logic [TMR_W-1:0] STBLO_LD = TMR_W'(STBLO_CYC - 1);
    localparam logic [TMR_W-1:0] GAP_LD   = TMR_W'(GAP_CYC - 1);
    localparam logic [TMR_W-1:0] PWR_LD   = TMR_W'(PWR_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    seq_state_e       state_q, state_d;
    logic             hi_q, hi_d;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic             strobe_q, strobe_d;
    pin_bus_t         pins_q;

    logic             tmr_done;
    logic             tmr_ld;
    logic [TMR_W-1:0] tmr_val;
    logic             sh_ld;
    logic             sh_shift;

    sdac_tmr #(
        .W       (TMR_W),
        .RST_VAL (PWR_LD)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sdac_shreg #(
        .W (WORD_W)
    ) u_shreg (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_ld),
        .shift (sh_shift),
        .din   (in_code),
        .msb   (sdo)
    );

    always_comb begin
        state_d  = state_q;
        hi_d     = hi_q;
        bit_d    = bit_q;
        strobe_d = strobe_q;
        tmr_ld   = 1'b0;
        tmr_val  = '0;
        sh_ld    = 1'b0;
        sh_shift = 1'b0;
        case (state_q)
            ST_PWRUP: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (in_valid) begin
                    state_d  = ST_CSSU;
                    strobe_d = use_strobe;
                    sh_ld    = 1'b1;
                    tmr_ld   = 1'b1;
                    tmr_val  = CSSU_LD;
                end
            end
            ST_CSSU: begin
                if (tmr_done) begin
                    state_d = ST_SHIFT;
                    hi_d    = 1'b1;
                    bit_d   = '0;
                    tmr_ld  = 1'b1;
                    tmr_val = HALF_LD;
                end
            end
            ST_SHIFT: begin
                if (tmr_done) begin
                    tmr_ld = 1'b1;
                    if (hi_q) begin
                        hi_d = 1'b0;
                        if (bit_q == LAST_BIT) begin
                            state_d = ST_CSHD;
                            tmr_val = CSHD_LD;
                        end else begin
                            bit_d    = bit_q + BIT_W'(1);
                            sh_shift = 1'b1;
                            tmr_val  = HALF_LD;
                        end
                    end else begin
                        hi_d    = 1'b1;
                        tmr_val = HALF_LD;
                    end
                end
            end
            ST_CSHD: begin
                if (tmr_done) begin
                    tmr_ld = 1'b1;
                    if (strobe_q) begin
                        state_d = ST_STBSU;
                        tmr_val = STBSU_LD;
                    end else begin
                        state_d = ST_GAP;
                        tmr_val = GAP_LD;
                    end
                end
            end
            ST_STBSU: begin
                if (tmr_done) begin
                    state_d = ST_STBLO;
                    tmr_ld  = 1'b1;
                    tmr_val = STBLO_LD;
                end
            end
            ST_STBLO: begin
                if (tmr_done) begin
                    state_d = ST_GAP;
                    tmr_ld  = 1'b1;
                    tmr_val = GAP_LD;
                end
            end
            ST_GAP: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_PWRUP;
            hi_q     <= 1'b0;
            bit_q    <= '0;
            strobe_q <= 1'b1;
            pins_q   <= '{cs_n: 1'b1, sclk: 1'b0, latch_n: 1'b1};
        end else begin
            state_q  <= state_d;
            hi_q     <= hi_d;
            bit_q    <= bit_d;
            strobe_q <= strobe_d;
            pins_q   <= pin_decode(state_d, hi_d, strobe_d);
        end
    end

    assign in_ready = (state_q == ST_IDLE);
    assign cs_n     = pins_q.cs_n;
    assign sclk     = pins_q.sclk;
    assign latch_n  = pins_q.latch_n;
endmodule

// File: rtl/sdac_wr_seq_chk.sv
module sdac_wr_seq_chk #(
    parameter int PWR_CYC = 1000
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic latch_n,
    input logic strobe_q
);
    int pw_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pw_cnt <= 0;
        end else if (pw_cnt < PWR_CYC) begin
            pw_cnt <= pw_cnt + 1;
        end
    end

    AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pw_cnt < PWR_CYC) |-> (!in_ready && cs_n)); // R1
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (cs_n && !sclk)); // R3
    AST_ACCEPT_STARTS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !cs_n); // R3
    AST_CS_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !sclk); // R4
    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n); // R5
    AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdo)); // R6
    AST_DIRECT_LATCH_LOW: assert property (@(posedge clk) disable iff (rst)
        !strobe_q |-> !latch_n); // R8
    AST_STROBE_HIGH_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && strobe_q) |-> latch_n); // R9
endmodule

bind sdac_wr_seq sdac_wr_seq_chk #(
    .PWR_CYC (PWR_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .sdo      (sdo),
    .latch_n  (latch_n),
    .strobe_q (strobe_q)
);

// File: tb/sdac_wr_seq_tb.sv
module sdac_wr_seq_tb;
    // Expected cycle counts at the default 20 ns clock.
    localparam int PWR     = 1000;
    localparam int HALF    = 3;
    localparam int CSSU    = 3;
    localparam int CS_LOW  = 99;   // CSSU + 16 high + 15 low phases + hold
    localparam int LAST_HI = 96;   // first cycle after the 16th high phase
    localparam int STB_BEG = 102;
    localparam int STB_END = 105;
    localparam int END_STB = 110;
    localparam int END_DIR = 104;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_code = '0;
    logic        use_strobe = 1'b0;
    logic        cs_n, sclk, sdo, latch_n;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    sdac_wr_seq u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_code    (in_code),
        .use_strobe (use_strobe),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdo        (sdo),
        .latch_n    (latch_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Offers a word at the current negedge, then compares every output in
    // every cycle up to the return of in_ready.
    task automatic run_frame(input logic [15:0] code, input bit strobe, input bit keep_valid,
                             input logic [15:0] next_code, input bit next_strobe);
        int endk;
        endk = strobe ? END_STB : END_DIR;
        while (!in_ready) @(negedge clk);
        in_valid   = 1'b1;
        in_code    = code;
        use_strobe = strobe;
        @(negedge clk);
        in_valid   = keep_valid;
        in_code    = next_code;
        use_strobe = next_strobe;
        for (int k = 0; k <= endk; k++) begin
            int exp_cs, exp_clk, exp_latch, exp_rdy, idx, exp_d;
            if (k > 0) @(negedge clk);
            exp_cs    = (k < CS_LOW) ? 0 : 1;
            exp_clk   = (k >= CSSU && k < LAST_HI && ((k - CSSU) % (2 * HALF)) < HALF) ? 1 : 0;
            exp_latch = strobe ? ((k >= STB_BEG && k < STB_END) ? 0 : 1) : 0;
            exp_rdy   = (k == endk) ? 1 : 0;
            chk((k == 0) ? "R3" : (k >= LAST_HI) ? "R7" : "R5", "cs_n", int'(cs_n), exp_cs);
            chk((k < CSSU) ? "R4" : "R5", "sclk", int'(sclk), exp_clk);
            if (k < CS_LOW) begin
                idx   = (k / (2 * HALF) > 15) ? 15 : k / (2 * HALF);
                exp_d = int'((code >> (15 - idx)) & 16'h1);
                chk("R6", "sdo", int'(sdo), exp_d);
            end
            chk(strobe ? "R9" : "R8", "latch_n", int'(latch_n), exp_latch);
            chk(strobe ? "R9" : "R8", "in_ready", int'(in_ready), exp_rdy);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R3", "idle in_ready", int'(in_ready), 1);
            chk("R3", "idle cs_n", int'(cs_n), 1);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] fixed [8];
        fixed = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001,
                  16'h7FFF, 16'hAAAA, 16'h5555, 16'hFFFE};

        // Reset state, with a word offered that must wait for power-up.
        in_valid   = 1'b1;
        in_code    = 16'h1234;
        use_strobe = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2", "reset cs_n", int'(cs_n), 1);
        chk("R2", "reset sclk", int'(sclk), 0);
        chk("R2", "reset latch_n", int'(latch_n), 1);
        chk("R2", "reset in_ready", int'(in_ready), 0);
        rst = 1'b0;

        // R1: power-up window, valid held high throughout.
        for (int n = 1; n <= PWR; n++) begin
            @(negedge clk);
            if (n == 1 || n >= PWR - 1 || (n % 100) == 0) begin
                chk("R1", "power-up in_ready", int'(in_ready), (n == PWR) ? 1 : 0);
                chk("R1", "power-up cs_n", int'(cs_n), 1);
            end else if (in_ready || !cs_n) begin
                chk("R1", "power-up quiet", int'({in_ready, cs_n}), 1);
            end
        end

        run_frame(16'h1234, 1'b1, 1'b0, 16'h0000, 1'b0);

        // Extremes and checkerboards in both update methods.
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 8; i++) begin
                run_frame(fixed[i], m[0], 1'b0, ~fixed[i], ~m[0]);
                if (i == 3) idle(4);
            end
        end

        // Walking one, alternating methods.
        for (int b = 0; b < 16; b++) begin
            run_frame(16'h1 << b, b[0], 1'b0, 16'hFFFF, 1'b1);
        end

        // R3: back-to-back words; the next word waits on in_valid during the frame.
        run_frame(16'hC3A5, 1'b1, 1'b1, 16'h3C5A, 1'b0);
        run_frame(16'h3C5A, 1'b0, 1'b1, 16'h9E37, 1'b1);
        run_frame(16'h9E37, 1'b1, 1'b0, 16'h0000, 1'b0);

        // Arithmetic code sweep.
        for (int j = 1; j <= 8; j++) begin
            run_frame(16'(j * 16'h2F1D + 16'h0101), (j % 3) != 0, 1'b0, 16'(j), 1'b0);
        end
        idle(2);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule